// File: doc/BRIEF.md
# Per-Position Blink Attribute Store with Blink Timer

This block keeps one blink flag for each of eight character positions on a multiplexed display and turns those flags into a per-position blank mask. A host uses the display's shared parallel bus. With the attribute-select line low, the host sets or clears a position's flag, or reads it back. The low three address bits pick the position. Bit 0 of the data bus carries the flag value.

A free-running divider splits the input clock into blink cycles of 28,672 clocks each. The divider sits in a lit phase for the first half of each cycle and in a blank phase for the second half. A position's blank-enable output is active only when three things hold together: the divider is in the blank phase, the global blink enable is high, and that position's flag is set. The display driver uses the mask to suppress the dots of flagged characters. For a nominal clock of about 57 kHz this gives a blink of about 2 Hz.

Top module: `flash_attr_blink`

## Requirements
- R1: While reset is held, and after it is released, every flag reads 0 and `blank_mask` is all zero.
- R2: A write sets the flag of position `bus_addr[2:0]` when `bus_wdata[0]` is 1. A write is a clock edge with `bus_sel_n`, `attr_sel_n` and `wstb_n` low and `rstb_n` high. Other positions keep their flags.
- R3: A write with `bus_wdata[0]` equal to 0 clears the flag of the addressed position.
- R4: `bus_addr[4:3]` and `bus_wdata[7:1]` have no effect on which flag is written or on its value.
- R5: While `bus_sel_n`, `attr_sel_n` and `rstb_n` are low, `bus_rdata` shows the addressed flag on bit 0 and zeros on bits 7..1. Outside such a read, `bus_rdata` is 0.
- R6: No flag changes at an edge where `bus_sel_n` or `attr_sel_n` is high.
- R7: The divider runs through 28,672 states and then wraps. Its blank phase lasts 14,336 consecutive clocks, followed by 14,336 lit clocks.
- R8: `blank_mask[i]` is 1 exactly when the divider is in the blank phase, `blink_en` is 1 and flag i is set. When `blink_en` is 0, the mask is 0.
- R9: An edge where `wstb_n` and `rstb_n` are both low writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the blink time base |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_n | input | 1 | Active-low chip select of the shared bus |
| attr_sel_n | input | 1 | Active-low select of the blink-flag store |
| wstb_n | input | 1 | Active-low write strobe |
| rstb_n | input | 1 | Active-low read strobe |
| bus_addr | input | 5 | Bus address; bits 2..0 pick the position |
| bus_wdata | input | 8 | Write data; bit 0 is the flag value |
| bus_rdata | output | 8 | Read data; flag on bit 0, other bits zero |
| blink_en | input | 1 | Global blink enable from the control word |
| blank_mask | output | 8 | Per-position blank enable, bit i for position i |

## Verification
The assertions assume that the bus inputs and `blink_en` are driven to known levels whenever the synchronised reset is released. They also assume that a strobe held low over several edges is meant to repeat the same access. The stimulus changes every bus input half a cycle away from the sampling edge. It keeps the bus idle, with all selects and strobes high, between accesses. It toggles `blink_en` only between samples.

// File: rtl/flash_attr_pkg.sv
package flash_attr_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_READ  = 2'd2
  } bus_cmd_e;
endpackage

// File: rtl/fa_rst_sync.sv
module fa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_q   <= stage_q;
    end
  end
endmodule

// File: rtl/fa_bus_decode.sv
module fa_bus_decode
  import flash_attr_pkg::*;
(
  input  logic     bus_sel_n,
  input  logic     attr_sel_n,
  input  logic     wstb_n,
  input  logic     rstb_n,
  output bus_cmd_e cmd
);
  always_comb begin
    cmd = CMD_IDLE;
    if (!bus_sel_n && !attr_sel_n) begin
      if (!wstb_n && rstb_n)      cmd = CMD_WRITE;
      else if (!rstb_n && wstb_n) cmd = CMD_READ;
      else if (!rstb_n)           cmd = CMD_READ;  // both strobes: read only
    end
  end
endmodule

// File: rtl/fa_attr_store.sv
module fa_attr_store #(
  parameter int NPOS = 8,
  localparam int IDX_W = $clog2(NPOS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic             wr_bit,
  output logic [NPOS-1:0]  attr_q,
  output logic             rd_bit
);
  logic [NPOS-1:0] attr_d;
  logic [NPOS-1:0] bit_en;

  // one clock enable per flag
  for (genvar i = 0; i < NPOS; i++) begin : g_flag
    assign bit_en[i] = wr_en && (idx == IDX_W'(i));

    always_comb begin
      attr_d[i] = attr_q[i];
      if (bit_en[i]) attr_d[i] = wr_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) attr_q[i] <= 1'b0;
      else        attr_q[i] <= attr_d[i];
    end
  end

  assign rd_bit = attr_q[idx];
endmodule

// File: rtl/fa_blink_div.sv
module fa_blink_div #(
  parameter int DIV_RATIO = 28672,
  localparam int CNT_W = $clog2(DIV_RATIO),
  localparam int HALF  = DIV_RATIO / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_q,
  output logic             blank_phase
);
  logic [CNT_W-1:0] cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == CNT_W'(DIV_RATIO - 1));

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
    if (at_end) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // second half of the count is the blank phase
  assign blank_phase = (cnt_q >= CNT_W'(HALF));
endmodule

// File: rtl/flash_attr_blink.sv
module flash_attr_blink
  import flash_attr_pkg::*;
#(
  parameter int NPOS      = 8,
  parameter int AW        = 5,
  parameter int DW        = 8,
  parameter int DIV_RATIO = 28672,
  localparam int IDX_W    = $clog2(NPOS),
  localparam int CNT_W    = $clog2(DIV_RATIO)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel_n,
  input  logic            attr_sel_n,
  input  logic            wstb_n,
  input  logic            rstb_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            blink_en,
  output logic [NPOS-1:0] blank_mask
);
  logic             rst_q;
  bus_cmd_e         cmd;
  logic [NPOS-1:0]  attr_q;
  logic             rd_bit;
  logic [CNT_W-1:0] cnt_q;
  logic             blank_phase;
  logic             unused_bits;

  assign unused_bits = ^{bus_addr[AW-1:IDX_W], bus_wdata[DW-1:1]};

  fa_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  fa_bus_decode u_dec (
    .bus_sel_n  (bus_sel_n),
    .attr_sel_n (attr_sel_n),
    .wstb_n     (wstb_n),
    .rstb_n     (rstb_n),
    .cmd        (cmd)
  );

  fa_attr_store #(.NPOS(NPOS)) u_store (
    .clk    (clk),
    .rst_n  (rst_q),
    .wr_en  (cmd == CMD_WRITE),
    .idx    (bus_addr[IDX_W-1:0]),
    .wr_bit (bus_wdata[0]),
    .attr_q (attr_q),
    .rd_bit (rd_bit)
  );

  fa_blink_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk         (clk),
    .rst_n       (rst_q),
    .cnt_q       (cnt_q),
    .blank_phase (blank_phase)
  );

  always_comb begin
    bus_rdata = '0;
    if (cmd == CMD_READ) bus_rdata[0] = rd_bit;
  end

  for (genvar i = 0; i < NPOS; i++) begin : g_mask
    assign blank_mask[i] = blank_phase & blink_en & attr_q[i];
  end
endmodule

// File: rtl/fa_blink_chk.sv
module fa_blink_chk #(
  parameter int NPOS      = 8,
  parameter int AW        = 5,
  parameter int DW        = 8,
  parameter int DIV_RATIO = 28672,
  localparam int IDX_W    = $clog2(NPOS),
  localparam int CNT_W    = $clog2(DIV_RATIO)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rst_q,
  input logic            bus_sel_n,
  input logic            attr_sel_n,
  input logic            wstb_n,
  input logic            rstb_n,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic            blink_en,
  input logic [NPOS-1:0] attr_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [NPOS-1:0] blank_mask
);
  logic wr_req;
  assign wr_req = !bus_sel_n && !attr_sel_n && !wstb_n && rstb_n;

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_q |-> (attr_q == '0) && (blank_mask == '0));

  p_write_set_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_req && bus_wdata[0]) |=> attr_q[$past(bus_addr[IDX_W-1:0])]);

  p_write_clear_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_req && !bus_wdata[0]) |=> !attr_q[$past(bus_addr[IDX_W-1:0])]);

  p_rdata_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_q)
    bus_rdata[DW-1:1] == '0);

  p_no_select_hold_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_sel_n || attr_sel_n) |=> $stable(attr_q));

  p_count_range_r7: assert property (@(posedge clk) disable iff (!rst_q)
    cnt_q < CNT_W'(DIV_RATIO));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (rst_q && $past(rst_q) && $past(cnt_q) != CNT_W'(DIV_RATIO - 1))
      |-> cnt_q == $past(cnt_q) + CNT_W'(1));

  p_mask_gate_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !blink_en |-> blank_mask == '0);

  p_mask_subset_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (blank_mask & ~attr_q) == '0);

  p_both_strobes_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (!wstb_n && !rstb_n) |=> $stable(attr_q));
endmodule

bind flash_attr_blink fa_blink_chk #(
  .NPOS(NPOS), .AW(AW), .DW(DW), .DIV_RATIO(DIV_RATIO)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_q      (rst_q),
  .bus_sel_n  (bus_sel_n),
  .attr_sel_n (attr_sel_n),
  .wstb_n     (wstb_n),
  .rstb_n     (rstb_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .blink_en   (blink_en),
  .attr_q     (attr_q),
  .cnt_q      (cnt_q),
  .blank_mask (blank_mask)
);

// File: tb/tb_flash_attr_blink.sv
`timescale 1ns/1ps
module tb_flash_attr_blink;
  localparam int HALF = 14336;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel_n, attr_sel_n, wstb_n, rstb_n;
  logic [4:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       blink_en;
  logic [7:0] blank_mask;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  flash_attr_blink dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel_n  (bus_sel_n),
    .attr_sel_n (attr_sel_n),
    .wstb_n     (wstb_n),
    .rstb_n     (rstb_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .blink_en   (blink_en),
    .blank_mask (blank_mask)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_idle();
    bus_sel_n = 1'b1; attr_sel_n = 1'b1; wstb_n = 1'b1; rstb_n = 1'b1;
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d,
                           input logic sel_n, input logic asel_n, input logic rd_too);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_sel_n = sel_n; attr_sel_n = asel_n;
    wstb_n = 1'b0; rstb_n = !rd_too;
    @(negedge clk);
    bus_idle();
  endtask

  task automatic bus_read(input logic [4:0] a, input logic asel_n, output logic [7:0] q);
    @(negedge clk);
    bus_addr = a; bus_sel_n = 1'b0; attr_sel_n = asel_n; rstb_n = 1'b0;
    #2 q = bus_rdata;
    @(negedge clk);
    bus_idle();
  endtask

  task automatic t_reset();
    logic [7:0] q;
    rst_n = 1'b0; blink_en = 1'b1; bus_idle(); bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    check(blank_mask == 8'h00, "R1 mask in reset", blank_mask, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      bus_read(5'(i), 1'b0, q);
      check(q == 8'h00, "R1 flag after reset", q, 0);
    end
    check(blank_mask == 8'h00, "R1 mask after reset", blank_mask, 0);
  endtask

  task automatic t_set_clear();
    logic [7:0] q;
    bus_write(5'd3, 8'h01, 1'b0, 1'b0, 1'b0);
    bus_read(5'd3, 1'b0, q);
    check(q == 8'h01, "R2 set pos3", q, 1);
    bus_read(5'd2, 1'b0, q);
    check(q == 8'h00, "R2 neighbour pos2 untouched", q, 0);
    bus_write(5'd3, 8'h00, 1'b0, 1'b0, 1'b0);
    bus_read(5'd3, 1'b0, q);
    check(q == 8'h00, "R3 clear pos3", q, 0);
  endtask

  task automatic t_ignored_bits();
    logic [7:0] q;
    bus_write(5'b11101, 8'hFE, 1'b0, 1'b0, 1'b0);
    bus_read(5'd5, 1'b0, q);
    check(q == 8'h00, "R4 upper data ignored", q, 0);
    bus_write(5'b10110, 8'h01, 1'b0, 1'b0, 1'b0);
    bus_read(5'b00110, 1'b0, q);
    check(q == 8'h01, "R4 upper addr ignored / R5 exact rdata", q, 1);
    bus_read(5'b11110, 1'b0, q);
    check(q == 8'h01, "R4 read upper addr ignored", q, 1);
    bus_read(5'd6, 1'b1, q);
    check(q == 8'h00, "R5 rdata zero without attr select", q, 0);
    bus_write(5'd6, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_no_select();
    logic [7:0] q;
    bus_write(5'd0, 8'h01, 1'b0, 1'b1, 1'b0);
    bus_read(5'd0, 1'b0, q);
    check(q == 8'h00, "R6 attr select high", q, 0);
    bus_write(5'd0, 8'h01, 1'b1, 1'b0, 1'b0);
    bus_read(5'd0, 1'b0, q);
    check(q == 8'h00, "R6 bus select high", q, 0);
    bus_write(5'd0, 8'h01, 1'b0, 1'b0, 1'b1);
    bus_read(5'd0, 1'b0, q);
    check(q == 8'h00, "R9 both strobes", q, 0);
  endtask

  task automatic t_blink();
    int n, bad;
    for (int i = 0; i < 8; i++)
      bus_write(5'(i), {7'b0, (8'h5A >> i) & 8'h01} , 1'b0, 1'b0, 1'b0);
    blink_en = 1'b1;
    n = 0;
    while (blank_mask != 8'h00 && n < 30000) begin @(negedge clk); n++; end
    n = 0;
    while (blank_mask == 8'h00 && n < 30000) begin @(negedge clk); n++; end
    n = 0; bad = 0;
    while (blank_mask != 8'h00 && n < 30000) begin
      if (blank_mask != 8'h5A) bad++;
      @(negedge clk); n++;
    end
    check(n == HALF, "R7 blank phase length", n, HALF);
    check(bad == 0, "R8 mask equals flags in blank phase", bad, 0);
    n = 0;
    while (blank_mask == 8'h00 && n < 30000) begin @(negedge clk); n++; end
    check(n == HALF, "R7 lit phase length", n, HALF);
    check(blank_mask == 8'h5A, "R8 mask pattern", blank_mask, 8'h5A);
    blink_en = 1'b0;
    #1 check(blank_mask == 8'h00, "R8 global enable off", blank_mask, 0);
    blink_en = 1'b1;
    #1 check(blank_mask == 8'h5A, "R8 global enable on", blank_mask, 8'h5A);
  endtask

  initial begin
    t_reset();
    t_set_clear();
    t_ignored_bits();
    t_no_select();
    t_blink();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(10 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule